// File: doc/BRIEF.md
# Multi-I/O Serial Flash Command Front-End

This block is the device side of the serial link of a small flash memory model. It runs on the serial clock. It takes in an instruction byte, a 24-bit address, optional dummy clocks and optional write data, then passes the bytes to or from a simple internal memory port. It moves data over one, two or four data lines. The line count depends on the selected protocol and, in the single-line protocol, on the instruction itself.

A configuration input picks the protocol: single-line with mixed-width instructions, all-dual, or all-quad. A second input turns on an execute-in-place read mode. In that mode a transaction carries no instruction byte. The host sends the address, waits a programmable number of dummy clocks, and then receives data. Configuration is captured only while the device is deselected, so a new setting applies from the next transaction.

The memory port reads combinationally. The block presents an address with a read-active flag and expects the byte back in the same cycle. Writes appear as a one-cycle strobe with the address and the byte.

Top module: `mioflash_front`

## Requirements
- R1: While `rst` is high and at the first edge after it falls, `dq_oe` is 0000 and `mem_wr` is 0.
- R2: Instruction bits are latched on rising edges from the first rising edge with `cs_n` low, most significant bit first. The line usage is: `dq_in[0]` only in single-line protocol (`cfg_proto`=0, 8 clocks); `dq_in[1:0]` in dual (`cfg_proto`=1, 4 clocks); `dq_in[3:0]` in quad (`cfg_proto`=2, 2 clocks). The higher-numbered line always carries the more significant bit.
- R3: In single-line protocol the opcodes set the address width, data width and dummy use: 03h (1,1, none), 0Bh (1,1, dummy), 3Bh (1,2, dummy), BBh (2,2, dummy), 6Bh (1,4, dummy), EBh (4,4, dummy), 02h (write, 1,1, none).
- R4: In dual or quad protocol every opcode listed in R3 uses the protocol's line count for both address and data. 03h and 02h take no dummy clocks; the other reads take dummy clocks.
- R5: The 24-bit address follows the instruction, most significant bit first. Reads that take dummy clocks then wait exactly `cfg_dummy` clocks. Line values during those clocks are ignored.
- R6: Read data is sent most significant bit first and changes on falling edges. The lines used are `dq_out[1]` for one line, `dq_out[1:0]` for two and `dq_out[3:0]` for four. `dq_oe` is 0010, 0011 or 1111 to match, and only during the data-out phase.
- R7: During a read the memory address advances by one after every complete byte, so consecutive bytes stream out.
- R8: Opcode 02h writes each complete received byte through a one-cycle `mem_wr` strobe at successive addresses. A trailing partial byte is discarded.
- R9: With `cfg_xip`=1 no opcode is sent. The address arrives at once on the protocol's line count, `cfg_dummy` clocks follow, and then data is read on that same line count.
- R10: Raising `cs_n` at any point removes `dq_oe` at once and restarts the sequencer, so the next transaction decodes from scratch.
- R11: An unrecognised opcode causes no output enable and no memory write until `cs_n` rises.
- R12: `cfg_proto`, `cfg_xip` and `cfg_dummy` are captured only at rising edges with `cs_n` high. A change while selected has no effect on the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled on rise, outputs updated on fall |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select |
| dq_in | input | 4 | Incoming values of the four data lines |
| dq_out | output | 4 | Outgoing values of the four data lines |
| dq_oe | output | 4 | Per-line output enable |
| cfg_proto | input | 2 | Protocol: 0 single, 1 dual, 2 quad (3 treated as single) |
| cfg_xip | input | 1 | Execute-in-place read mode |
| cfg_dummy | input | 4 | Dummy clock count for reads that use dummy clocks |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | High while the data-out phase reads memory |
| mem_rdata | input | 8 | Memory byte at `mem_addr`, combinational |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to write |

## Verification
Every read opcode is run in the single-line protocol. Each address-width and data-width pairing therefore shows up separately in clock counts and in which lines carry data. The dual and quad protocols repeat reads and writes, which separates the instruction width from the data width. Execute-in-place runs in both single and quad protocols. Edge cases are exercised by a read cut off mid-byte followed by a fresh read, a write ending in a partial byte, an unknown opcode, and a protocol change made while selected.

// File: rtl/mioflash_pkg.sv
package mioflash_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DOUT,
        ST_DIN,
        ST_DROP
    } seq_st_e;

    // lane code: 0 = one line, 1 = two lines, 2 = four lines
    typedef logic [1:0] lanes_t;

    typedef struct packed {
        logic   ok;
        logic   wr;
        lanes_t aw;
        lanes_t dw;
        logic   dmy;
    } op_info_t;

    function automatic lanes_t proto_lanes(logic [1:0] p);
        return (p == 2'd3) ? 2'd0 : p;
    endfunction

    function automatic logic [7:0] shift_byte(logic [7:0] s, lanes_t l, logic [3:0] d);
        case (l)
            2'd1:    return {s[5:0], d[1:0]};
            2'd2:    return {s[3:0], d};
            default: return {s[6:0], d[0]};
        endcase
    endfunction

    function automatic op_info_t decode_op(lanes_t pl, logic [7:0] op);
        op_info_t i;
        i = '0;
        if (pl == 2'd0) begin
            case (op)
                8'h03: i.ok = 1'b1;
                8'h0B: begin i.ok = 1'b1; i.dmy = 1'b1; end
                8'h3B: begin i.ok = 1'b1; i.dmy = 1'b1; i.dw = 2'd1; end
                8'hBB: begin i.ok = 1'b1; i.dmy = 1'b1; i.aw = 2'd1; i.dw = 2'd1; end
                8'h6B: begin i.ok = 1'b1; i.dmy = 1'b1; i.dw = 2'd2; end
                8'hEB: begin i.ok = 1'b1; i.dmy = 1'b1; i.aw = 2'd2; i.dw = 2'd2; end
                8'h02: begin i.ok = 1'b1; i.wr = 1'b1; end
                default: i.ok = 1'b0;
            endcase
        end else begin
            i.aw = pl;
            i.dw = pl;
            case (op)
                8'h03: i.ok = 1'b1;
                8'h0B, 8'h3B, 8'hBB, 8'h6B, 8'hEB: begin i.ok = 1'b1; i.dmy = 1'b1; end
                8'h02: begin i.ok = 1'b1; i.wr = 1'b1; end
                default: i.ok = 1'b0;
            endcase
        end
        return i;
    endfunction

endpackage

// File: rtl/mioflash_seq.sv
module mioflash_seq
    import mioflash_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int DUMMY_W   = 4,
    localparam int CW = (($clog2(ADDR_BITS) > DUMMY_W) ? $clog2(ADDR_BITS) : DUMMY_W) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic [3:0]           dq_in,
    input  logic [1:0]           cfg_proto,
    input  logic                 cfg_xip,
    input  logic [DUMMY_W-1:0]   cfg_dummy,
    output seq_st_e              st,
    output logic [ADDR_BITS-1:0] addr,
    output lanes_t               dw_q,
    output logic [CW-1:0]        cnt,
    output logic                 wr_pend,
    output logic [7:0]           wdata
);

    lanes_t             pl_q, aw_q;
    logic               wr_q;
    logic [DUMMY_W-1:0] dmy_q;
    logic [7:0]         sh;
    logic [7:0]         op_next, din_next;
    op_info_t           info;
    logic [CW-1:0]      op_last, addr_last, dmy_last, byte_last;

    function automatic logic [ADDR_BITS-1:0] addr_shift(logic [ADDR_BITS-1:0] a, lanes_t l,
                                                        logic [3:0] d);
        case (l)
            2'd1:    return {a[ADDR_BITS-3:0], d[1:0]};
            2'd2:    return {a[ADDR_BITS-5:0], d};
            default: return {a[ADDR_BITS-2:0], d[0]};
        endcase
    endfunction

    always_comb begin
        op_next   = shift_byte(sh, pl_q, dq_in);
        din_next  = shift_byte(sh, dw_q, dq_in);
        info      = decode_op(pl_q, op_next);
        op_last   = CW'((8 >> pl_q) - 1);
        addr_last = CW'((ADDR_BITS >> aw_q) - 1);
        byte_last = CW'((8 >> dw_q) - 1);
        dmy_last  = CW'(int'(dmy_q) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_OPC;
            cnt     <= '0;
            addr    <= '0;
            sh      <= '0;
            pl_q    <= '0;
            aw_q    <= '0;
            dw_q    <= '0;
            wr_q    <= 1'b0;
            dmy_q   <= '0;
            wr_pend <= 1'b0;
            wdata   <= '0;
        end else if (cs_n) begin
            st      <= cfg_xip ? ST_ADDR : ST_OPC;
            cnt     <= '0;
            pl_q    <= proto_lanes(cfg_proto);
            aw_q    <= proto_lanes(cfg_proto);
            dw_q    <= proto_lanes(cfg_proto);
            dmy_q   <= cfg_dummy;
            wr_q    <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            wr_pend <= 1'b0;
            case (st)
                ST_OPC: begin
                    sh <= op_next;
                    if (cnt == op_last) begin
                        cnt <= '0;
                        if (info.ok) begin
                            st    <= ST_ADDR;
                            aw_q  <= info.aw;
                            dw_q  <= info.dw;
                            wr_q  <= info.wr;
                            dmy_q <= info.dmy ? dmy_q : '0;
                        end else begin
                            st <= ST_DROP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    addr <= addr_shift(addr, aw_q, dq_in);
                    if (cnt == addr_last) begin
                        cnt <= '0;
                        if (wr_q)            st <= ST_DIN;
                        else if (dmy_q != 0) st <= ST_DUMMY;
                        else                 st <= ST_DOUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DUMMY: begin
                    if (cnt == dmy_last) begin
                        cnt <= '0;
                        st  <= ST_DOUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DOUT: begin
                    if (cnt == byte_last) begin
                        cnt  <= '0;
                        addr <= addr + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DIN: begin
                    sh <= din_next;
                    if (wr_pend) addr <= addr + 1'b1;
                    if (cnt == byte_last) begin
                        cnt     <= '0;
                        wdata   <= din_next;
                        wr_pend <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mioflash_drv.sv
module mioflash_drv
    import mioflash_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  lanes_t        lanes,
    input  logic [CW-1:0] beat,
    input  logic [7:0]    rdata,
    output logic [3:0]    out_q,
    output logic [3:0]    oe_q
);

    logic [7:0] sl;
    logic [3:0] out_n, oe_n;

    always_comb begin
        sl    = rdata << (int'(beat) << lanes);
        out_n = '0;
        oe_n  = '0;
        if (active) begin
            case (lanes)
                2'd1:    begin out_n = {2'b00, sl[7:6]};      oe_n = 4'b0011; end
                2'd2:    begin out_n = sl[7:4];               oe_n = 4'b1111; end
                default: begin out_n = {2'b00, sl[7], 1'b0};  oe_n = 4'b0010; end
            endcase
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
        end else begin
            out_q <= out_n;
            oe_q  <= oe_n;
        end
    end

endmodule

// File: rtl/mioflash_front.sv
module mioflash_front
    import mioflash_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int DUMMY_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic [3:0]           dq_in,
    output logic [3:0]           dq_out,
    output logic [3:0]           dq_oe,
    input  logic [1:0]           cfg_proto,
    input  logic                 cfg_xip,
    input  logic [DUMMY_W-1:0]   cfg_dummy,
    output logic [ADDR_BITS-1:0] mem_addr,
    output logic                 mem_rd,
    input  logic [7:0]           mem_rdata,
    output logic                 mem_wr,
    output logic [7:0]           mem_wdata
);

    localparam int CW = (($clog2(ADDR_BITS) > DUMMY_W) ? $clog2(ADDR_BITS) : DUMMY_W) + 1;

    seq_st_e       st;
    lanes_t        dw;
    logic [CW-1:0] cnt;
    logic [3:0]    oe_q;

    mioflash_seq #(.ADDR_BITS(ADDR_BITS), .DUMMY_W(DUMMY_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .dq_in     (dq_in),
        .cfg_proto (cfg_proto),
        .cfg_xip   (cfg_xip),
        .cfg_dummy (cfg_dummy),
        .st        (st),
        .addr      (mem_addr),
        .dw_q      (dw),
        .cnt       (cnt),
        .wr_pend   (mem_wr),
        .wdata     (mem_wdata)
    );

    assign mem_rd = (st == ST_DOUT);

    mioflash_drv #(.CW(CW)) u_drv (
        .clk    (clk),
        .rst    (rst),
        .active (mem_rd),
        .lanes  (dw),
        .beat   (cnt),
        .rdata  (mem_rdata),
        .out_q  (dq_out),
        .oe_q   (oe_q)
    );

    assign dq_oe = oe_q & {4{~cs_n}};

endmodule

// File: rtl/mioflash_chk.sv
module mioflash_chk #(
    parameter int ADDR_BITS = 24
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           dq_oe,
    input logic [ADDR_BITS-1:0] mem_addr,
    input logic                 mem_rd,
    input logic                 mem_wr
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!mem_wr && dq_oe == 4'b0000));

    // R6
    oe_shape_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe inside {4'b0000, 4'b0010, 4'b0011, 4'b1111});

    // R6
    oe_in_dataphase_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != 4'b0000) |-> mem_rd);

    // R7
    rd_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd) && mem_addr != $past(mem_addr))
            |-> mem_addr == ADDR_BITS'($past(mem_addr) + 1));

    // R8
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

    // R8
    wr_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_rd);

endmodule

bind mioflash_front mioflash_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dq_oe    (dq_oe),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr)
);

// File: tb/mioflash_front_test.sv
module mioflash_front_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out, dq_oe;
    logic [1:0]  cfg_proto = 2'd0;
    logic        cfg_xip = 1'b0;
    logic [3:0]  cfg_dummy = 4'd8;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_rdata, mem_wdata;

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    logic [3:0] qi[$];
    logic [3:0] qo[$];
    logic [3:0] qd[$];

    int checks = 0;
    int fails = 0;
    int mid_cfg = -1;
    bit no_wr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    mioflash_front uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cfg_proto(cfg_proto), .cfg_xip(cfg_xip), .cfg_dummy(cfg_dummy),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put(logic [31:0] v, int nbits, int lines);
        for (int i = 0; i < nbits / lines; i++) begin
            logic [31:0] t;
            t = v >> (nbits - lines * (i + 1));
            qi.push_back(4'(t) & 4'((1 << lines) - 1));
            qo.push_back(4'h0);
            qd.push_back(4'h0);
        end
    endtask

    task automatic put_dummy(int n);
        for (int i = 0; i < n; i++) begin
            qi.push_back(4'hA);
            qo.push_back(4'h0);
            qd.push_back(4'h0);
        end
    endtask

    task automatic put_read(int a, int n, int lines);
        for (int b = 0; b < n; b++) begin
            logic [7:0] v;
            v = ref_mem[(a + b) & 255];
            for (int i = 0; i < 8 / lines; i++) begin
                logic [7:0] t;
                t = v >> (8 - lines * (i + 1));
                qi.push_back(4'h0);
                if (lines == 1) begin
                    qo.push_back(4'b0010); qd.push_back({2'b00, t[0], 1'b0});
                end else if (lines == 2) begin
                    qo.push_back(4'b0011); qd.push_back({2'b00, t[1:0]});
                end else begin
                    qo.push_back(4'b1111); qd.push_back(t[3:0]);
                end
            end
        end
    endtask

    task automatic put_write(int a, int n, int lines);
        for (int b = 0; b < n; b++) begin
            logic [7:0] v;
            v = 8'(8'hC3 ^ ((a + b) * 29));
            put({24'h0, v}, 8, lines);
            ref_mem[(a + b) & 255] = v;
        end
    endtask

    task automatic idle(int k, string tag);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); #1;
            cs_n = 1'b1;
            chk(tag, dq_oe, 4'h0);
        end
    endtask

    task automatic run(string tag, int limit);
        int n;
        n = (limit < 0) ? qi.size() : limit;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk(tag, dq_oe, qo[i]);
            if (qo[i] != 4'h0) chk(tag, dq_out & qo[i], qd[i]);
            if (no_wr) chk({tag, " no write"}, {3'b000, mem_wr}, 4'h0);
            if (i == 4 && mid_cfg >= 0) cfg_proto = 2'(mid_cfg);
            cs_n = 1'b0;
            dq_in = qi[i];
        end
        @(negedge clk); #1;
        cs_n = 1'b1;
        dq_in = 4'h0;
        #1;
        chk({tag, " R10 deselect"}, dq_oe, 4'h0);
        qi.delete();
        qo.delete();
        qd.delete();
        idle(2, tag);
    endtask

    task automatic set_cfg(logic [1:0] p, logic x, logic [3:0] d);
        @(negedge clk); #1;
        cfg_proto = p;
        cfg_xip = x;
        cfg_dummy = d;
        idle(2, "R12 config");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] <= 8'(i * 37 + 11);
            ref_mem[i] = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 oe in reset", dq_oe, 4'h0);
        chk("R1 wr in reset", {3'b000, mem_wr}, 4'h0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 wr after reset", {3'b000, mem_wr}, 4'h0);
        idle(2, "R1 idle");

        // R2 R5 R6 R7: plain single-line read, no dummy
        put(32'h03, 8, 1); put(32'h000010, 24, 1); put_read(16, 3, 1);
        run("R2 R7 single read", -1);

        // R5: fast read with 8 dummy clocks
        put(32'h0B, 8, 1); put(32'h000020, 24, 1); put_dummy(8); put_read(32, 2, 1);
        run("R5 fast read", -1);

        // R3: dual output
        put(32'h3B, 8, 1); put(32'h000031, 24, 1); put_dummy(8); put_read(49, 2, 2);
        run("R3 dual-out read", -1);

        // R3: dual address and data
        put(32'hBB, 8, 1); put(32'h000042, 24, 2); put_dummy(8); put_read(66, 2, 2);
        run("R3 dual-io read", -1);

        // R3: quad output
        put(32'h6B, 8, 1); put(32'h000050, 24, 1); put_dummy(8); put_read(80, 3, 4);
        run("R3 quad-out read", -1);

        // R3 R12: quad address and data, new dummy count
        set_cfg(2'd0, 1'b0, 4'd4);
        put(32'hEB, 8, 1); put(32'h0000F0, 24, 4); put_dummy(4); put_read(240, 3, 4);
        run("R3 quad-io read", -1);

        // R8: single-line program then read back
        put(32'h02, 8, 1); put(32'h000040, 24, 1); put_write(64, 3, 1);
        run("R8 program", -1);
        put(32'h03, 8, 1); put(32'h000040, 24, 1); put_read(64, 3, 1);
        run("R8 readback", -1);

        // R11: unknown opcode then clocks with data
        no_wr = 1'b1;
        put(32'h55, 8, 1); put(32'hFFFFFF, 24, 1); put(32'hFFFF, 16, 1);
        run("R11 unknown opcode", -1);
        no_wr = 1'b0;

        // R10: read cut mid-byte, then fresh read
        put(32'h0B, 8, 1); put(32'h000070, 24, 1); put_dummy(4); put_read(112, 2, 1);
        run("R10 cut read", 8 + 24 + 4 + 8 + 3);
        put(32'h03, 8, 1); put(32'h000090, 24, 1); put_read(144, 2, 1);
        run("R10 read after cut", -1);

        // R8: partial trailing byte discarded
        put(32'h02, 8, 1); put(32'h000080, 24, 1); put_write(128, 1, 1); put(32'h5, 4, 1);
        run("R8 partial write", -1);
        put(32'h03, 8, 1); put(32'h000080, 24, 1); put_read(128, 2, 1);
        run("R8 partial readback", -1);

        // R2 R4: dual protocol
        set_cfg(2'd1, 1'b0, 4'd6);
        put(32'h03, 8, 2); put(32'h0000A0, 24, 2); put_read(160, 2, 2);
        run("R4 dual proto read", -1);
        put(32'h6B, 8, 2); put(32'h0000A8, 24, 2); put_dummy(6); put_read(168, 2, 2);
        run("R4 dual proto fast read", -1);

        // R2 R4 R8: quad protocol
        set_cfg(2'd2, 1'b0, 4'd3);
        put(32'h0B, 8, 4); put(32'h0000B0, 24, 4); put_dummy(3); put_read(176, 3, 4);
        run("R4 quad proto fast read", -1);
        put(32'h02, 8, 4); put(32'h0000C0, 24, 4); put_write(192, 2, 4);
        run("R8 quad program", -1);
        put(32'h03, 8, 4); put(32'h0000C0, 24, 4); put_read(192, 2, 4);
        run("R8 quad readback", -1);

        // R9: execute-in-place, single then quad
        set_cfg(2'd0, 1'b1, 4'd5);
        put(32'h0000D0, 24, 1); put_dummy(5); put_read(208, 2, 1);
        run("R9 xip single", -1);
        set_cfg(2'd2, 1'b1, 4'd2);
        put(32'h0000E0, 24, 4); put_dummy(2); put_read(224, 3, 4);
        run("R9 xip quad", -1);

        // R12: protocol change while selected is ignored
        set_cfg(2'd0, 1'b0, 4'd8);
        mid_cfg = 2;
        put(32'h03, 8, 1); put(32'h000011, 24, 1); put_read(17, 2, 1);
        run("R12 change while selected", -1);
        mid_cfg = -1;
        set_cfg(2'd0, 1'b0, 4'd8);
        put(32'h03, 8, 1); put(32'h000012, 24, 1); put_read(18, 1, 1);
        run("R12 after restore", -1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule